// File: doc/BRIEF.md
# Matched Filter and Symbol Sampler

This block sits on the receive side of a binary phase-shift keyed link. It takes complex baseband samples that have already been corrected for carrier offset. I and Q are signed 16-bit values with 15 fraction bits, and several samples arrive per symbol. Both lanes pass through one 65-tap root-raised-cosine filter, using the same coefficient set that the transmit shaper uses. The taps are real, so each lane is a plain real convolution. Products carry 30 fraction bits. The sum is held in an accumulator with seven guard bits. The result is rounded and clamped back to the 16-bit format.

After the filter, a sampler counts settled filter outputs modulo the configured samples-per-symbol. It emits one sample per symbol at a fixed, programmed phase offset. Each emitted symbol carries its I and Q values and a hard-decision bit. Two running counters record headroom violations at the output node and the number of symbols decided, so the fixed-point sizing can be judged while traffic flows.

The tap set, the samples-per-symbol value and the offset are held steady by the surrounding logic. Changes take effect only after a reset.

Top module: `rrc_matched_sampler`

## Requirements
- R1: For each accepted input, both lanes output y = clamp(floor((sum over k of h[k]*x[n-k] + 2^14) / 2^15)), with h[k] = taps_i[16k+15:16k] (signed) and x[n-k] the k-th most recent accepted sample. The sum over k runs from 0 to 64. Samples older than reset count as zero. The clamp range is -32768..32767, and I and Q use the same taps.
- R2: A sample accepted with valid_i high at a rising edge gives filt_valid_o high for exactly one cycle, after the second following rising edge. Cycles with valid_i low neither shift the history nor produce an output.
- R3: The first 64 filter outputs after reset have filt_warm_o high and never produce a symbol. Every later output has filt_warm_o low.
- R4: Settled (non-warm-up) outputs are numbered from 0 modulo sps_i. When an output's number equals offset_i, sym_valid_o is high one cycle after that output, and sym_re_o and sym_im_o equal it.
- R5: While offset_i >= sps_i, no symbol is emitted and sym_cnt_o stays unchanged.
- R6: sym_bit_o is 0 when the emitted sym_re_o is zero or positive, and 1 when it is negative.
- R7: sat_cnt_o increments by one, one cycle after each filter output in which I, Q or both were clamped. It wraps modulo 2^16.
- R8: sym_cnt_o increments by one in each cycle that sym_valid_o is high and holds otherwise.
- R9: While rst_ni is low, every output is zero and the sample history is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample strobe |
| samp_re_i | input | 16 | In-phase input sample, signed, 15 fraction bits |
| samp_im_i | input | 16 | Quadrature input sample, signed, 15 fraction bits |
| taps_i | input | 1040 | 65 signed 16-bit filter taps, tap k at bits 16k+15:16k |
| sps_i | input | 8 | Samples per symbol, 1 or more |
| offset_i | input | 8 | Symbol sampling phase |
| filt_valid_o | output | 1 | Filter output strobe |
| filt_warm_o | output | 1 | Current filter output is still in warm-up |
| filt_re_o | output | 16 | Filtered in-phase sample |
| filt_im_o | output | 16 | Filtered quadrature sample |
| sym_valid_o | output | 1 | Symbol strobe |
| sym_re_o | output | 16 | Sampled in-phase symbol |
| sym_im_o | output | 16 | Sampled quadrature symbol |
| sym_bit_o | output | 1 | Hard-decision bit |
| sat_cnt_o | output | 16 | Clamp event count |
| sym_cnt_o | output | 16 | Decided symbol count |

## Verification
A clamp event and a symbol decision land in the same cycle when the filter output picked as a symbol is itself clamped. Both counters then step on one edge, and the symbol must carry the clamped full-scale value. The bench provokes this with all taps near half scale and long runs of full-scale positive and most-negative input, at two samples per symbol, so clamped outputs fall on both phases. A per-cycle reference model predicts the clamped value, the decision bit and both counter steps, and every clock is compared against it. The last warm-up output and the first settled one also meet at phase zero. This case is covered with one sample per symbol and a zero offset.

// File: rtl/rmf_pkg.sv
package rmf_pkg;
  localparam int SAMP_W     = 16;
  localparam int COEF_W     = 16;
  localparam int PROD_W     = SAMP_W + COEF_W;
  localparam int FRAC_SHIFT = COEF_W - 1;
  localparam int N_LANES    = 2;

  typedef logic signed [SAMP_W-1:0] samp_t;

  typedef enum logic {
    LANE_RE = 1'b0,
    LANE_IM = 1'b1
  } lane_e;
endpackage

// File: rtl/rmf_tapline.sv
module rmf_tapline
  import rmf_pkg::*;
#(
  parameter int NUM_TAPS = 65
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       en_i,
  input  samp_t                      din_i,
  output logic [NUM_TAPS*SAMP_W-1:0] line_o
);
  // stage 0 holds the newest sample
  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_stage
    logic [SAMP_W-1:0] q;
    if (g == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   q <= '0;
        else if (en_i) q <= din_i;
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   q <= '0;
        else if (en_i) q <= g_stage[g-1].q;
      end
    end
    assign line_o[g*SAMP_W +: SAMP_W] = q;
  end
endmodule

// File: rtl/rmf_mac.sv
module rmf_mac
  import rmf_pkg::*;
#(
  parameter int NUM_TAPS = 65,
  parameter int ACC_W    = 39
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       en_i,
  input  logic [NUM_TAPS*SAMP_W-1:0] line_i,
  input  logic [NUM_TAPS*COEF_W-1:0] taps_i,
  output samp_t                      y_o,
  output logic                       sat_o
);
  localparam logic signed [ACC_W-1:0] RND_HALF =
    {{(ACC_W-FRAC_SHIFT){1'b0}}, 1'b1, {(FRAC_SHIFT-1){1'b0}}};
  localparam logic signed [ACC_W-1:0] POS_LIM =
    {{(ACC_W-SAMP_W+1){1'b0}}, {(SAMP_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] NEG_LIM =
    {{(ACC_W-SAMP_W+1){1'b1}}, {(SAMP_W-1){1'b0}}};

  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  rnd;
  logic signed [ACC_W-1:0]  shv;
  logic                     sat_hi, sat_lo;
  samp_t                    y_d;

  always_comb begin
    acc  = '0;
    prod = '0;
    for (int k = 0; k < NUM_TAPS; k++) begin
      prod = $signed(line_i[k*SAMP_W +: SAMP_W]) * $signed(taps_i[k*COEF_W +: COEF_W]);
      acc  = acc + ACC_W'(prod);
    end
    rnd    = acc + RND_HALF;
    shv    = rnd >>> FRAC_SHIFT;
    sat_hi = shv > POS_LIM;
    sat_lo = shv < NEG_LIM;
    if (sat_hi)      y_d = {1'b0, {(SAMP_W-1){1'b1}}};
    else if (sat_lo) y_d = {1'b1, {(SAMP_W-1){1'b0}}};
    else             y_d = shv[SAMP_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_o   <= '0;
      sat_o <= 1'b0;
    end else if (en_i) begin
      y_o   <= y_d;
      sat_o <= sat_hi | sat_lo;
    end
  end

  // a flagged clamp must leave a full-scale value
  assert_clamp_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_o |-> (y_o == {1'b0, {(SAMP_W-1){1'b1}}} || y_o == {1'b1, {(SAMP_W-1){1'b0}}}));
endmodule

// File: rtl/rmf_sampler.sv
module rmf_sampler
  import rmf_pkg::*;
#(
  parameter int SPS_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             filt_valid_i,
  input  logic             filt_warm_i,
  input  samp_t            filt_re_i,
  input  samp_t            filt_im_i,
  input  logic             sat_i,
  input  logic [SPS_W-1:0] sps_i,
  input  logic [SPS_W-1:0] offset_i,
  output logic             sym_valid_o,
  output samp_t            sym_re_o,
  output samp_t            sym_im_o,
  output logic             sym_bit_o,
  output logic [CNT_W-1:0] sat_cnt_o,
  output logic [CNT_W-1:0] sym_cnt_o
);
  logic [SPS_W-1:0] phase_q;
  logic             settled, hit;

  assign settled = filt_valid_i & ~filt_warm_i;
  assign hit     = settled && (phase_q == offset_i) && (offset_i < sps_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      phase_q <= '0;
    else if (settled) phase_q <= (phase_q >= sps_i - SPS_W'(1)) ? '0 : phase_q + SPS_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sym_valid_o <= 1'b0;
      sym_re_o    <= '0;
      sym_im_o    <= '0;
      sym_bit_o   <= 1'b0;
      sym_cnt_o   <= '0;
    end else begin
      sym_valid_o <= hit;
      if (hit) begin
        sym_re_o  <= filt_re_i;
        sym_im_o  <= filt_im_i;
        sym_bit_o <= filt_re_i[SAMP_W-1];
        sym_cnt_o <= sym_cnt_o + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    sat_cnt_o <= '0;
    else if (filt_valid_i && sat_i) sat_cnt_o <= sat_cnt_o + CNT_W'(1);
  end

  assert_no_warm_sym_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_valid_o |-> $past(filt_valid_i && !filt_warm_i));
  assert_offset_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_valid_o |-> $past(offset_i < sps_i));
  assert_decision_sign_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_valid_o |-> (sym_bit_o == sym_re_o[SAMP_W-1]));
  assert_sym_count_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_valid_o |-> (sym_cnt_o == $past(sym_cnt_o) + CNT_W'(1)));
  assert_sym_count_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sym_valid_o |-> $stable(sym_cnt_o));
endmodule

// File: rtl/rrc_matched_sampler.sv
module rrc_matched_sampler
  import rmf_pkg::*;
#(
  parameter int NUM_TAPS = 65,
  parameter int SPS_W    = 8,
  parameter int CNT_W    = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       valid_i,
  input  logic [SAMP_W-1:0]          samp_re_i,
  input  logic [SAMP_W-1:0]          samp_im_i,
  input  logic [NUM_TAPS*COEF_W-1:0] taps_i,
  input  logic [SPS_W-1:0]           sps_i,
  input  logic [SPS_W-1:0]           offset_i,
  output logic                       filt_valid_o,
  output logic                       filt_warm_o,
  output logic [SAMP_W-1:0]          filt_re_o,
  output logic [SAMP_W-1:0]          filt_im_o,
  output logic                       sym_valid_o,
  output logic [SAMP_W-1:0]          sym_re_o,
  output logic [SAMP_W-1:0]          sym_im_o,
  output logic                       sym_bit_o,
  output logic [CNT_W-1:0]           sat_cnt_o,
  output logic [CNT_W-1:0]           sym_cnt_o
);
  localparam int GUARD_W = $clog2(NUM_TAPS);
  localparam int ACC_W   = PROD_W + GUARD_W;
  localparam int WARM_N  = NUM_TAPS - 1;
  localparam int WCNT_W  = $clog2(NUM_TAPS);

  logic [N_LANES-1:0][SAMP_W-1:0] lane_in;
  logic [N_LANES-1:0][SAMP_W-1:0] lane_y;
  logic [N_LANES-1:0]             lane_sat;

  logic [WCNT_W-1:0] warm_cnt_q;
  logic              line_valid_q, line_warm_q;
  logic              filt_valid_q, filt_warm_q;

  assign lane_in[LANE_RE] = samp_re_i;
  assign lane_in[LANE_IM] = samp_im_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      warm_cnt_q   <= '0;
      line_valid_q <= 1'b0;
      line_warm_q  <= 1'b0;
      filt_valid_q <= 1'b0;
      filt_warm_q  <= 1'b0;
    end else begin
      line_valid_q <= valid_i;
      line_warm_q  <= valid_i && (warm_cnt_q < WCNT_W'(WARM_N));
      if (valid_i && (warm_cnt_q < WCNT_W'(WARM_N))) warm_cnt_q <= warm_cnt_q + WCNT_W'(1);
      filt_valid_q <= line_valid_q;
      filt_warm_q  <= line_valid_q & line_warm_q;
    end
  end

  for (genvar l = 0; l < N_LANES; l++) begin : g_lane
    logic [NUM_TAPS*SAMP_W-1:0] line;

    rmf_tapline #(.NUM_TAPS(NUM_TAPS)) u_line (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (valid_i),
      .din_i  (lane_in[l]),
      .line_o (line)
    );

    rmf_mac #(.NUM_TAPS(NUM_TAPS), .ACC_W(ACC_W)) u_mac (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (line_valid_q),
      .line_i (line),
      .taps_i (taps_i),
      .y_o    (lane_y[l]),
      .sat_o  (lane_sat[l])
    );
  end

  assign filt_valid_o = filt_valid_q;
  assign filt_warm_o  = filt_warm_q;
  assign filt_re_o    = lane_y[LANE_RE];
  assign filt_im_o    = lane_y[LANE_IM];

  rmf_sampler #(.SPS_W(SPS_W), .CNT_W(CNT_W)) u_sampler (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .filt_valid_i (filt_valid_q),
    .filt_warm_i  (filt_warm_q),
    .filt_re_i    (lane_y[LANE_RE]),
    .filt_im_i    (lane_y[LANE_IM]),
    .sat_i        (|lane_sat),
    .sps_i        (sps_i),
    .offset_i     (offset_i),
    .sym_valid_o  (sym_valid_o),
    .sym_re_o     (sym_re_o),
    .sym_im_o     (sym_im_o),
    .sym_bit_o    (sym_bit_o),
    .sat_cnt_o    (sat_cnt_o),
    .sym_cnt_o    (sym_cnt_o)
  );

  assert_out_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    filt_valid_o |-> $past(valid_i, 2));
  assert_warm_needs_valid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    filt_warm_o |-> filt_valid_o);
endmodule

// File: tb/tb_rrc_matched_sampler.sv
module tb_rrc_matched_sampler;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 65;
  localparam int SW = 8;
  localparam int CW = 16;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic             rst_ni = 1'b0;
  logic             valid_i = 1'b0;
  logic [15:0]      samp_re_i = '0, samp_im_i = '0;
  logic [NT*16-1:0] taps_i = '0;
  logic [SW-1:0]    sps_i = 8'd4, offset_i = 8'd1;
  logic             filt_valid_o, filt_warm_o, sym_valid_o, sym_bit_o;
  logic [15:0]      filt_re_o, filt_im_o, sym_re_o, sym_im_o;
  logic [CW-1:0]    sat_cnt_o, sym_cnt_o;

  rrc_matched_sampler dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i),
    .samp_re_i(samp_re_i), .samp_im_i(samp_im_i), .taps_i(taps_i),
    .sps_i(sps_i), .offset_i(offset_i),
    .filt_valid_o(filt_valid_o), .filt_warm_o(filt_warm_o),
    .filt_re_o(filt_re_o), .filt_im_o(filt_im_o),
    .sym_valid_o(sym_valid_o), .sym_re_o(sym_re_o), .sym_im_o(sym_im_o),
    .sym_bit_o(sym_bit_o), .sat_cnt_o(sat_cnt_o), .sym_cnt_o(sym_cnt_o)
  );

  typedef struct { int due; int re; int im; bit warm; } fev_t;
  typedef struct { int due; int re; int im; } sev_t;

  int   tap_v[NT];
  int   h_re[NT];
  int   h_im[NT];
  fev_t fq[$];
  sev_t sq[$];
  int   satq[$];
  int   n_in, phase, t, exp_sat, exp_sym;
  int   n_tests = 0, n_fail = 0;
  bit   done = 0;

  task automatic chk(bit ok, string rq, string what, longint act, longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, expv);
    end
  endtask

  function automatic int round_clamp(longint acc, output bit s);
    longint r;
    r = (acc + 64'sd16384) >>> 15;
    s = 0;
    if (r > 32767)  begin r = 32767;  s = 1; end
    if (r < -32768) begin r = -32768; s = 1; end
    return int'(r);
  endfunction

  task automatic set_taps(int kind);
    for (int k = 0; k < NT; k++) begin
      int d;
      d = k - 32;
      case (kind)
        0: tap_v[k] = (d == 0) ? 12000 : ((d % 4 == 0) ? -1500 : 3000 / ((d < 0 ? -d : d) + 1));
        1: tap_v[k] = 16000;
        default: tap_v[k] = ((k * 37) % 200 - 100) * 50;
      endcase
      taps_i[k*16 +: 16] = 16'(tap_v[k]);
    end
  endtask

  task automatic check_cycle();
    fev_t f;
    sev_t s;
    if (fq.size() > 0 && fq[0].due == t) begin
      f = fq.pop_front();
      chk(filt_valid_o == 1'b1, "R2", "filter strobe missing", filt_valid_o, 1);
      chk($signed(filt_re_o) == f.re, "R1", "filtered I", $signed(filt_re_o), f.re);
      chk($signed(filt_im_o) == f.im, "R1", "filtered Q", $signed(filt_im_o), f.im);
      chk(filt_warm_o == f.warm, "R3", "warm-up flag", filt_warm_o, f.warm);
    end else begin
      chk(filt_valid_o == 1'b0, "R2", "spurious filter strobe", filt_valid_o, 0);
    end
    while (satq.size() > 0 && satq[0] == t) begin
      exp_sat++;
      void'(satq.pop_front());
    end
    if (sq.size() > 0 && sq[0].due == t) begin
      s = sq.pop_front();
      exp_sym++;
      chk(sym_valid_o == 1'b1, "R4", "symbol strobe missing", sym_valid_o, 1);
      chk($signed(sym_re_o) == s.re, "R4", "symbol I", $signed(sym_re_o), s.re);
      chk($signed(sym_im_o) == s.im, "R4", "symbol Q", $signed(sym_im_o), s.im);
      chk(sym_bit_o == (s.re < 0), "R6", "decision bit", sym_bit_o, (s.re < 0));
    end else begin
      chk(sym_valid_o == 1'b0, "R4", "spurious symbol strobe", sym_valid_o, 0);
    end
    chk(sat_cnt_o == 16'(exp_sat), "R7", "clamp count", sat_cnt_o, 16'(exp_sat));
    chk(sym_cnt_o == 16'(exp_sym), "R8", "symbol count", sym_cnt_o, 16'(exp_sym));
  endtask

  task automatic model(int re, int im);
    longint ar, ai;
    bit sr, si, warm;
    fev_t f;
    sev_t s;
    for (int k = NT - 1; k > 0; k--) begin
      h_re[k] = h_re[k-1];
      h_im[k] = h_im[k-1];
    end
    h_re[0] = re;
    h_im[0] = im;
    ar = 0;
    ai = 0;
    for (int k = 0; k < NT; k++) begin
      ar += longint'(tap_v[k]) * longint'(h_re[k]);
      ai += longint'(tap_v[k]) * longint'(h_im[k]);
    end
    warm = (n_in < NT - 1);
    if (warm) n_in++;
    f.due = t + 2;
    f.re = round_clamp(ar, sr);
    f.im = round_clamp(ai, si);
    f.warm = warm;
    fq.push_back(f);
    if (sr || si) satq.push_back(t + 3);
    if (!warm) begin
      if (phase == int'(offset_i) && offset_i < sps_i) begin
        s.due = t + 3;
        s.re = f.re;
        s.im = f.im;
        sq.push_back(s);
      end
      phase = (phase >= int'(sps_i) - 1) ? 0 : phase + 1;
    end
  endtask

  task automatic drive(bit v, int re, int im);
    @(negedge clk);
    t++;
    check_cycle();
    valid_i   = v;
    samp_re_i = 16'(re);
    samp_im_i = 16'(im);
    if (v) model(re, im);
  endtask

  task automatic do_reset(int kind, int sps, int off);
    @(negedge clk);
    rst_ni  = 1'b0;
    valid_i = 1'b0;
    set_taps(kind);
    sps_i    = SW'(sps);
    offset_i = SW'(off);
    repeat (3) @(negedge clk);
    // R9: all outputs cleared while reset is held
    chk(filt_valid_o == 0 && filt_warm_o == 0 && filt_re_o == 0 && filt_im_o == 0,
        "R9", "filter outputs in reset", filt_re_o, 0);
    chk(sym_valid_o == 0 && sym_re_o == 0 && sym_im_o == 0 && sym_bit_o == 0,
        "R9", "symbol outputs in reset", sym_re_o, 0);
    chk(sat_cnt_o == 0 && sym_cnt_o == 0, "R9", "counters in reset", sat_cnt_o + sym_cnt_o, 0);
    for (int k = 0; k < NT; k++) begin
      h_re[k] = 0;
      h_im[k] = 0;
    end
    fq.delete();
    sq.delete();
    satq.delete();
    n_in = 0; phase = 0; exp_sat = 0; exp_sym = 0; t = 0;
    rst_ni = 1'b1;
  endtask

  function automatic int rnd16();
    return int'($urandom_range(0, 65535)) - 32768;
  endfunction

  task automatic flush();
    repeat (6) drive(1'b0, 0, 0);
  endtask

  initial begin
    // phase A: continuous input, 4 samples per symbol, offset 1
    do_reset(0, 4, 1);
    for (int i = 0; i < 300; i++) drive(1'b1, rnd16() / 2, rnd16() / 2);
    flush();

    // phase B: gapped input, asymmetric taps, offset at the top of the range
    do_reset(2, 8, 7);
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 9) < 6) drive(1'b1, rnd16(), rnd16());
      else                          drive(1'b0, rnd16(), rnd16());
    end
    flush();

    // phase C: R5 offset equal to sps, nothing may be decided
    do_reset(0, 4, 4);
    for (int i = 0; i < 200; i++) drive(1'b1, rnd16(), rnd16());
    flush();
    chk(sym_cnt_o == 0, "R5", "symbols decided with offset >= sps", sym_cnt_o, 0);

    // phase D: clamping coincides with symbol decisions
    do_reset(1, 2, 1);
    for (int i = 0; i < 260; i++) begin
      int blk;
      blk = (i / 80) % 3;
      if (blk == 0)      drive(1'b1, 32767, -32768);
      else if (blk == 1) drive(1'b1, -32768, 32767);
      else               drive(1'b1, 0, 1000);
    end
    flush();
    chk(exp_sat > 0 && sat_cnt_o == 16'(exp_sat), "R7", "clamp events seen", sat_cnt_o, exp_sat);

    // phase E: every settled output is a symbol; long zero run gives I == 0
    do_reset(0, 1, 0);
    for (int i = 0; i < 150; i++) drive(1'b1, 0, 0);
    for (int i = 0; i < 100; i++) drive(1'b1, rnd16(), rnd16());
    flush();
    chk(sym_cnt_o == 16'(250 - (NT - 1)), "R3", "symbols after warm-up", sym_cnt_o, 250 - (NT - 1));

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", 150000);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule